// File: doc/BRIEF.md
# Sixteen-Bit UV-EPROM Control Model

This block is a synthesizable behavioural model of the control side of a sixteen-bit, ultraviolet-erasable EPROM. It can stand in for a real part inside a testbench or an emulator. On every clock it samples the active-low chip and output enables. It also samples three boolean flags that stand for analog levels: output enable raised to the identifier or high voltage, the A9 identifier voltage, and the programming supply. From these it decodes the bus state into one mode: read, output disable, standby, identifier, word program, verify, optional verify, program inhibit, or one of the page-programming steps.

Page programming is a sticky mode. It is armed by a high-voltage strobe on output enable while the chip is deselected and the programming supply is present. In this mode, data for four consecutive words is gathered in a latch, and one programming pulse then writes the whole page. The mode ends only when the programming supply is withdrawn. Programming ANDs new data into the stored word, so bits can only be cleared. Reset plays the part of an ultraviolet erase and returns every stored bit to one.

The data output and its drive enable are combinational from the current inputs and the stored state. All writes take effect at the next rising clock edge.

Top module: `eprom_ctrl_model`

## Requirements
- R1: With the programming supply off, `ce_n`=0, `oe_n`=0, `oe_hv`=0 and `a9_hv`=0, `dout_en`=1 and `dout` equals the word stored at the address.
- R2: With the programming supply off and `ce_n`=0, an output enable that is high (`oe_n`=1 or `oe_hv`=1) gives `dout_en`=0 and `dout`=0.
- R3: With the programming supply off and `ce_n`=1, the block is in standby: `dout_en`=0 and `dout`=0, whatever the other inputs are.
- R4: Page mode starts at the clock edge where `vpp_hv`=1, `ce_n`=1 and `oe_hv`=1. It stays on through any later inputs until a clock edge sees `vpp_hv`=0.
- R5: In page mode, a cycle with `ce_n`=0 and `oe_hv`=1 stores `din` into latch slot `addr[1:0]`. The latch does not drive the outputs.
- R6: In page mode, a cycle with `ce_n`=0, `oe_n`=1 and `oe_hv`=0 ANDs latch slot k into the word at page index `addr[AW-1:2]`, offset k, for all four slots.
- R7: In page mode, `ce_n`=1 with `oe_n`=0 and `oe_hv`=0 drives the stored word at the address. Every other page-mode combination not named in R5 or R6 floats the outputs.
- R8: Outside page mode with `vpp_hv`=1, `ce_n`=0, `oe_n`=1 and `oe_hv`=0 ANDs `din` into the word at the address.
- R9: Outside page mode with `vpp_hv`=1 and `oe_n`=0, `oe_hv`=0, the stored word is driven both with `ce_n`=1 (verify) and with `ce_n`=0 (optional verify). With both enables high the outputs float.
- R10: With the programming supply off, `a9_hv`=1 and both enables low, `dout` is 16'h0007 when `addr[0]`=0 and 16'h00A2 when `addr[0]`=1, with `dout_en`=1.
- R11: After reset, every stored word and every latch slot is 16'hFFFF and page mode is off.
- R12: Only `addr[AW-1:0]` selects a word (AW = log2 of the depth, 8 by default). Addresses that differ only above that reach the same word.
- R13: A program operation can only clear bits: the new word is the old word AND the programmed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, acts as a full erase |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| oe_hv | input | 1 | Output enable held at the high voltage; counts as high |
| a9_hv | input | 1 | A9 held at the identifier voltage |
| vpp_hv | input | 1 | Programming supply at programming level |
| addr | input | 18 | Word address |
| din | input | 16 | Data to program or latch |
| dout | output | 16 | Read, verify or identifier data; zero when floated |
| dout_en | output | 1 | Output drive enable |

## Verification
The directed phase covers the hazards that matter most. A page program is started after arming and before the supply is withdrawn. Then a word program follows the withdrawal: if the model kept page mode, it would rewrite the page from the latch and leave the target word all ones. Programming the same word twice with overlapping data exposes a model that overwrites instead of ANDing. A read at an aliased address exposes one that uses the full address. Both identifier codes are read, as is the erased state. A long random phase mixes enables, high-voltage flags and clustered addresses. Its results are compared cycle by cycle against a bench reference model, which catches wrong floating in the page-set and page-idle states and a wrong choice of latch slot.

// File: rtl/eprom_pkg.sv
// Package: shared mode encoding for the EPROM control model.
package eprom_pkg;
    typedef enum logic [3:0] {
        M_STANDBY,
        M_READ,
        M_DISABLE,
        M_IDENT,
        M_WPROG,
        M_VERIFY,
        M_OPTVER,
        M_INHIBIT,
        M_PSET,
        M_PLATCH,
        M_PPROG,
        M_PVERIFY,
        M_PIDLE
    } mode_e;
endpackage

// File: rtl/eprom_mode_decode.sv
// Module: eprom_mode_decode
// Decodes the sampled bus state into one operating mode. It holds the sticky
// page-mode flag.
// Assumes: oe_hv means output enable is above logic high, so it counts as high.
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  oe_hv,
    input  logic  a9_hv,
    input  logic  vpp_hv,
    output mode_e mode,
    output logic  page_on
);
    logic page_q;
    logic oe_high;

    assign oe_high = oe_n | oe_hv;
    assign page_on = page_q;

    // Sticky page flag: armed by the high-voltage strobe, dropped when the supply goes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        page_q <= 1'b0;
        else if (!vpp_hv)                  page_q <= 1'b0;
        else if (ce_n && oe_hv)            page_q <= 1'b1;
    end

    // Mode selection from the enables, the high-voltage flags and the page flag.
    always_comb begin
        mode = M_STANDBY;
        if (!vpp_hv) begin
            if (ce_n)            mode = M_STANDBY;
            else if (oe_high)    mode = M_DISABLE;
            else if (a9_hv)      mode = M_IDENT;
            else                 mode = M_READ;
        end else if (ce_n && oe_hv) begin
            mode = M_PSET;
        end else if (page_q) begin
            if (!ce_n && oe_hv)        mode = M_PLATCH;
            else if (!ce_n && oe_high) mode = M_PPROG;
            else if (ce_n && !oe_high) mode = M_PVERIFY;
            else                       mode = M_PIDLE;
        end else begin
            if (!ce_n && oe_hv)        mode = M_INHIBIT;
            else if (!ce_n && oe_n)    mode = M_WPROG;
            else if (ce_n && !oe_n)    mode = M_VERIFY;
            else if (!ce_n && !oe_n)   mode = M_OPTVER;
            else                       mode = M_INHIBIT;
        end
    end

    // R4
    page_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hv && ce_n && oe_hv) |=> page_q);
    // R4
    page_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hv |=> !page_q);
endmodule

// File: rtl/eprom_page_latch.sv
// Module: eprom_page_latch
// Holds the words gathered before a page program. One slot is written per
// latch cycle.
// Assumes: SLOTS is a power of two.
module eprom_page_latch #(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 4,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SW-1:0]               sel,
    input  logic [DATA_W-1:0]           din,
    output logic [SLOTS-1:0][DATA_W-1:0] words
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Slot register: erased to ones, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                      words[s] <= '1;
            else if (we && sel == SW'(s))    words[s] <= din;
        end
    end

    // R5
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> words[$past(sel)] == $past(din));
endmodule

// File: rtl/eprom_word_array.sv
// Module: eprom_word_array
// The stored words. A single-word or whole-page program ANDs data in, so bits
// can only be cleared. Reset erases every word to all ones.
// Assumes: DEPTH is a power of two and a multiple of SLOTS.
module eprom_word_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int SLOTS  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         word_we,
    input  logic                         page_we,
    input  logic [AW-1:0]                idx,
    input  logic [DATA_W-1:0]            word_din,
    input  logic [SLOTS-1:0][DATA_W-1:0] page_words,
    output logic [DATA_W-1:0]            rd_word
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_word = mem_q[idx];

    // Erase on reset; AND-in a word or a full page on a program cycle.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem_q[i] <= '1;
            else if (word_we && idx == AW'(i))
                mem_q[i] <= mem_q[i] & word_din;
            else if (page_we && (AW'(i) >> SW) == (idx >> SW))
                mem_q[i] <= mem_q[i] & page_words[SW'(i)];
        end
    end

    // R13
    no_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |=> (mem_q[$past(idx)] & ~$past(rd_word)) == '0);
endmodule

// File: rtl/eprom_ctrl_model.sv
// Module: eprom_ctrl_model
// Top of the EPROM control model: mode decode, page latch, word array and
// the output mux.
// Assumes: analog levels arrive as booleans; reset stands for a UV erase.
module eprom_ctrl_model #(
    parameter int          ADDR_W = 18,
    parameter int          DATA_W = 16,
    parameter int          DEPTH  = 256,
    parameter int          SLOTS  = 4,
    parameter logic [7:0]  ID_MFR = 8'h07,
    parameter logic [7:0]  ID_DEV = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic              vpp_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import eprom_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int SW = $clog2(SLOTS);

    mode_e                         mode;
    logic                          page_on;
    logic [AW-1:0]                 idx;
    logic [SLOTS-1:0][DATA_W-1:0]  latch_words;
    logic [DATA_W-1:0]             rd_word;

    assign idx = addr[AW-1:0];

    eprom_mode_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .oe_hv   (oe_hv),
        .a9_hv   (a9_hv),
        .vpp_hv  (vpp_hv),
        .mode    (mode),
        .page_on (page_on)
    );

    eprom_page_latch #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode == M_PLATCH),
        .sel   (addr[SW-1:0]),
        .din   (din),
        .words (latch_words)
    );

    eprom_word_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLOTS(SLOTS)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (mode == M_WPROG),
        .page_we    (mode == M_PPROG),
        .idx        (idx),
        .word_din   (din),
        .page_words (latch_words),
        .rd_word    (rd_word)
    );

    // Output mux: stored word, identifier code, or floated (zero).
    always_comb begin
        dout_en = 1'b0;
        dout    = '0;
        unique case (mode)
            M_READ, M_VERIFY, M_OPTVER, M_PVERIFY: begin
                dout_en = 1'b1;
                dout    = rd_word;
            end
            M_IDENT: begin
                dout_en = 1'b1;
                dout    = DATA_W'(addr[0] ? ID_DEV : ID_MFR);
            end
            default: begin
                dout_en = 1'b0;
                dout    = '0;
            end
        endcase
    end

    // R3
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hv && ce_n) |-> (!dout_en && dout == '0));
    // R2
    disable_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hv && !ce_n && (oe_n || oe_hv)) |-> !dout_en);
    // R10
    ident_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hv && !ce_n && !oe_n && !oe_hv && a9_hv) |-> (dout_en && dout[DATA_W-1:8] == '0));
    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_on && vpp_hv) |=> page_on);
endmodule

// File: tb/test_eprom_ctrl_model.sv
// Bench for eprom_ctrl_model: a directed sequence plus seeded random bus
// traffic, compared with a reference model kept in bench functions.
module test_eprom_ctrl_model;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0, vpp_hv = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mdl_mem [256];
    logic [15:0] mdl_lat [4];
    bit          mdl_pg;
    logic [15:0] s_dout;
    logic        s_en;

    always #5 clk = ~clk;

    eprom_ctrl_model i_eprom_ctrl_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe_hv(oe_hv),
        .a9_hv(a9_hv), .vpp_hv(vpp_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(bit c, bit o, bit h, bit a9, bit v);
        bit oh = o | h;
        if (!v) return c ? "R3" : (oh ? "R2" : (a9 ? "R10" : "R1"));
        if (c && h) return "R4";
        if (mdl_pg) return (!c && h) ? "R5" : ((!c && oh) ? "R6" : "R7");
        return (!c && o && !h) ? "R8" : "R9";
    endfunction

    // Drive one bus cycle, check the outputs, then advance the reference model.
    task automatic step(bit c, bit o, bit h, bit a9, bit v, logic [17:0] a, logic [15:0] d);
        bit          oh = o | h;
        bit          en_x = 1'b0;
        logic [15:0] d_x = '0;
        bit          pg_old;
        @(negedge clk);
        ce_n = c; oe_n = o; oe_hv = h; a9_hv = a9; vpp_hv = v; addr = a; din = d;
        #1;
        if (!v) begin
            if (!c && !oh) begin
                en_x = 1'b1;
                d_x  = a9 ? (a[0] ? 16'h00A2 : 16'h0007) : mdl_mem[a[7:0]];
            end
        end else if (!(c && h)) begin
            if (mdl_pg) begin
                if (c && !oh) begin en_x = 1'b1; d_x = mdl_mem[a[7:0]]; end
            end else if (!oh) begin
                en_x = 1'b1; d_x = mdl_mem[a[7:0]];
            end
        end
        s_dout = dout; s_en = dout_en;
        chk(tag_of(c, o, h, a9, v), {dout_en, dout}, {en_x, d_x});
        pg_old = mdl_pg;
        if (v && !(c && h)) begin
            if (pg_old && !c && h) mdl_lat[a[1:0]] = d;
            else if (pg_old && !c && oh)
                for (int k = 0; k < 4; k++)
                    mdl_mem[{a[7:2], 2'(k)}] = mdl_mem[{a[7:2], 2'(k)}] & mdl_lat[k];
            else if (!pg_old && !c && o && !h) mdl_mem[a[7:0]] = mdl_mem[a[7:0]] & d;
        end
        if (!v) mdl_pg = 1'b0;
        else if (c && h) mdl_pg = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mdl_mem[i] = 16'hFFFF;
        for (int k = 0; k < 4; k++) mdl_lat[k] = 16'hFFFF;
        mdl_pg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: erased state after reset
        step(0, 0, 0, 0, 0, 18'h00000, 16'h0);
        chk("R11 erased word", {s_en, s_dout}, {1'b1, 16'hFFFF});
        step(0, 0, 0, 0, 0, 18'h000FF, 16'h0);
        chk("R11 erased top word", {s_en, s_dout}, {1'b1, 16'hFFFF});

        // R10: identifier codes
        step(0, 0, 0, 1, 0, 18'h00000, 16'h0);
        chk("R10 maker code", {s_en, s_dout}, {1'b1, 16'h0007});
        step(0, 0, 0, 1, 0, 18'h00001, 16'h0);
        chk("R10 device code", {s_en, s_dout}, {1'b1, 16'h00A2});

        // R8 / R9 / R13 / R12: word program, verify, AND, aliasing
        step(0, 1, 0, 0, 1, 18'h00005, 16'h1234);
        step(1, 0, 0, 0, 1, 18'h00005, 16'h0);
        chk("R9 verify after R8 program", {s_en, s_dout}, {1'b1, 16'h1234});
        step(0, 1, 0, 0, 1, 18'h00005, 16'hFF00);
        step(0, 0, 0, 0, 1, 18'h00005, 16'h0);
        chk("R13 optional verify after AND", {s_en, s_dout}, {1'b1, 16'h1200});
        step(0, 0, 0, 0, 0, 18'h3FF05, 16'h0);
        chk("R12 aliased read", {s_en, s_dout}, {1'b1, 16'h1200});

        // R4 / R5 / R6 / R7: page flow
        step(1, 1, 1, 0, 1, 18'h00020, 16'h0);
        step(1, 1, 0, 0, 1, 18'h00020, 16'h0);
        chk("R7 page idle floats", {s_en, s_dout}, {1'b0, 16'h0000});
        step(0, 1, 1, 0, 1, 18'h10020, 16'hF0F0);
        chk("R5 latch cycle floats", {s_en, s_dout}, {1'b0, 16'h0000});
        step(0, 1, 1, 0, 1, 18'h10021, 16'h0F0F);
        step(0, 1, 1, 0, 1, 18'h10022, 16'h1357);
        step(0, 1, 1, 0, 1, 18'h10023, 16'hFFFF);
        step(0, 1, 0, 0, 1, 18'h00021, 16'h0000);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] want [4] = '{16'hF0F0, 16'h0F0F, 16'h1357, 16'hFFFF};
            step(1, 0, 0, 0, 1, 18'h00020 + 18'(k), 16'h0);
            chk("R6 page word via R7 verify", {s_en, s_dout}, {1'b1, want[k]});
        end
        step(1, 1, 0, 0, 0, 18'h0, 16'h0);
        step(0, 1, 0, 0, 1, 18'h00023, 16'h00FF);
        step(1, 0, 0, 0, 1, 18'h00023, 16'h0);
        chk("R4 page mode left after supply drop", {s_en, s_dout}, {1'b1, 16'h00FF});

        // Random traffic against the reference model (all requirements)
        begin
            bit v = 1'b0;
            for (int n = 0; n < 6000; n++) begin
                logic [17:0] a = 18'($urandom);
                if ($urandom % 16 == 0) v = ~v;
                if ($urandom % 2 == 0) a[7:4] = 4'h0;
                step(1'($urandom), 1'($urandom), ($urandom % 4 == 0),
                     ($urandom % 4 == 0), v, a, 16'($urandom));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule